// File: doc/BRIEF.md
# Write-Through Two-Way L1 Data Cache

This block is a first-level data cache for a 32-bit processor data port. It sits between the processor and a private second-level cache. It holds 8 KB in two ways of 128 sets, with 32-byte lines. A load that finds its line is answered in the same cycle it is presented. A load that misses stalls the processor while the whole line is fetched from the next level. The fetched line is written into the way that the set's replacement bit names, and the load is then retried and hits.

Stores never allocate. Every store is passed straight to the next level as a single-word write, and the processor is granted in the cycle the next level accepts it. If the store hits, the enabled bytes of the cached word are merged at that same edge, so the next level and the cache never disagree.

The next level may invalidate a line at any time through a dedicated address port, for example after incoming DMA has changed the memory behind that line. Invalidation has priority over a processor access to the same set in the same cycle. An invalidation that targets a line while that line is being filled cancels the fill.

Top module: `dcache_wt`

## Requirements
- R1: The address splits into a word offset in bits [4:2], a set index in bits [11:5] and a tag in bits [31:12]. Each set holds two lines, so two lines with the same index and different tags are cached together.
- R2: A store presented while the cache is idle raises nl_req_o and nl_we_o in the same cycle, with nl_addr_o, nl_be_o and nl_wdata_o equal to the processor's address, byte enables and data. cpu_gnt_o is high in exactly the cycle nl_gnt_i is high.
- R3: A store that misses changes no line (no write-allocate). It causes no line fetch, and a later load to the same address misses.
- R4: A store that hits writes only the bytes whose cpu_be_i bit is 1 (bit n covers data bits 8n+7:8n) into the cached word. A later load returns the merged word without a next-level request.
- R5: A load hit raises cpu_gnt_o in the same cycle the request is presented, with valid cpu_rdata_o, and issues no next-level request.
- R6: A load miss withholds cpu_gnt_o and issues one read (nl_we_o low, nl_addr_o line-aligned with bits [4:0] zero). The read is held until nl_gnt_i. Eight words then arrive on nl_rvalid_i in ascending word order, possibly with gaps, after which the load hits.
- R7: One replacement bit per set names the victim way. It is 0 after reset and is set to the way not used by each load or store hit. A miss evicts the named way.
- R8: inv_i with inv_addr_i removes the line in that set whose tag matches, so the next load to it misses. An invalidation whose tag matches no line leaves the set unchanged.
- R9: When inv_i targets the same set as the processor access in the same cycle, that access gets no grant and issues no next-level write. It proceeds in a later cycle.
- R10: An invalidation matching the line being fetched, from the read request until the last word, leaves that line invalid, so the retried load fetches it again.
- R11: After reset every line is invalid, and cpu_gnt_o and nl_req_o are low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor access request, held until granted |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 32 | Byte address |
| cpu_be_i | input | 4 | Store byte enables |
| cpu_wdata_i | input | 32 | Store data |
| cpu_gnt_o | output | 1 | Access completes this cycle |
| cpu_rdata_o | output | 32 | Load data, valid with cpu_gnt_o on a load |
| nl_req_o | output | 1 | Next-level request |
| nl_we_o | output | 1 | Next-level request is a write |
| nl_addr_o | output | 32 | Next-level address |
| nl_be_o | output | 4 | Next-level byte enables |
| nl_wdata_o | output | 32 | Next-level write data |
| nl_gnt_i | input | 1 | Next level accepts the request |
| nl_rvalid_i | input | 1 | One fill word is on nl_rdata_i |
| nl_rdata_i | input | 32 | Fill word |
| inv_i | input | 1 | Invalidate request |
| inv_addr_i | input | 32 | Address of the line to invalidate |

## Verification
Internal state errors show up at the ports in only two ways: a hit or miss that does not match what the access history predicts, or load data that differs from the next-level memory model. A wrong replacement bit shows up on the next miss in that set, as an extra fetch when a line that should still be resident is loaded again. A lost or missing invalidation shows up on the first load to that line afterwards, as stale data or an unexpected hit. A bad merge of a store hit shows up at the first later load of that word. This is why the stimulus always follows each state change with a load that exposes it.

// File: rtl/dcache_wt_pkg.sv
package dcache_wt_pkg;
  localparam int unsigned NUM_WAYS = 2;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_FILL} miss_st_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int unsigned SET_W = 7,
  parameter int unsigned TAG_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic [1:0]       lk_hit_o,
  output logic             lk_victim_o,
  input  logic             iv_en_i,
  input  logic [SET_W-1:0] iv_set_i,
  input  logic [TAG_W-1:0] iv_tag_i,
  input  logic             touch_en_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic             touch_way_i,
  input  logic             drop_en_i,
  input  logic [SET_W-1:0] drop_set_i,
  input  logic             drop_way_i,
  input  logic             fill_en_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic             fill_way_i,
  input  logic [TAG_W-1:0] fill_tag_i
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [SETS-1:0][1:0] valid_q;
  logic [SETS-1:0]      lru_q;
  logic [TAG_W-1:0]     tag_q [2][SETS];
  logic [1:0]           iv_hit;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign lk_hit_o[w] = valid_q[lk_set_i][w] && (tag_q[w][lk_set_i] == lk_tag_i);
    assign iv_hit[w]   = valid_q[iv_set_i][w] && (tag_q[w][iv_set_i] == iv_tag_i);
  end

  assign lk_victim_o = lru_q[lk_set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      if (drop_en_i) valid_q[drop_set_i][drop_way_i] <= 1'b0;
      if (fill_en_i) valid_q[fill_set_i][fill_way_i] <= 1'b1;
      // invalidation last: it wins any same-cycle update
      if (iv_en_i) begin
        for (int w = 0; w < 2; w++) begin
          if (iv_hit[w]) valid_q[iv_set_i][w] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lru_q <= '0;
    else if (touch_en_i) lru_q[touch_set_i] <= ~touch_way_i;
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) tag_q[fill_way_i][fill_set_i] <= fill_tag_i;
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_hit_o)); // R1
  AST_INV_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iv_en_i && (iv_hit != 2'b00)) |=> ((valid_q[$past(iv_set_i)] & $past(iv_hit)) == 2'b00)); // R8
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int unsigned SET_W  = 7,
  parameter int unsigned WORD_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic [SET_W-1:0]       rd_set_i,
  input  logic [WORD_W-1:0]      rd_word_i,
  output logic [1:0][DATA_W-1:0] rd_data_o,
  input  logic                   wr_en_i,
  input  logic                   wr_way_i,
  input  logic [SET_W-1:0]       wr_set_i,
  input  logic [WORD_W-1:0]      wr_word_i,
  input  logic [DATA_W/8-1:0]    wr_be_i,
  input  logic [DATA_W-1:0]      wr_data_i
);
  localparam int unsigned BE_W  = DATA_W / 8;
  localparam int unsigned IDX_W = 1 + SET_W + WORD_W;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  wr_idx;

  assign wr_idx = {wr_way_i, wr_set_i, wr_word_i};

  for (genvar w = 0; w < 2; w++) begin : g_rd
    assign rd_data_o[w] = mem_q[{w[0], rd_set_i, rd_word_i}];
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be_i[b]) mem_q[wr_idx][b*8 +: 8] <= wr_data_i[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/dc_miss_fsm.sv
module dc_miss_fsm
  import dcache_wt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SET_W    = 7,
  parameter int unsigned TAG_W    = 20,
  parameter int unsigned WORD_W   = 3,
  parameter int unsigned LINE_OFF = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SET_W-1:0]  start_set_i,
  input  logic [TAG_W-1:0]  start_tag_i,
  input  logic              start_way_i,
  input  logic              nl_gnt_i,
  input  logic              nl_rvalid_i,
  input  logic              iv_en_i,
  input  logic [SET_W-1:0]  iv_set_i,
  input  logic [TAG_W-1:0]  iv_tag_i,
  output miss_st_e          state_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              fill_we_o,
  output logic [SET_W-1:0]  fill_set_o,
  output logic              fill_way_o,
  output logic [WORD_W-1:0] fill_word_o,
  output logic [TAG_W-1:0]  fill_tag_o,
  output logic              fill_done_o
);
  localparam logic [WORD_W-1:0] LAST_BEAT = '1;

  miss_st_e          st_q;
  logic [SET_W-1:0]  set_q;
  logic [TAG_W-1:0]  tag_q;
  logic              way_q;
  logic [WORD_W-1:0] beat_q;
  logic              poison_q;
  logic              iv_match;

  assign iv_match = iv_en_i && (iv_set_i == set_q) && (iv_tag_i == tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      set_q    <= '0;
      tag_q    <= '0;
      way_q    <= 1'b0;
      beat_q   <= '0;
      poison_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q     <= ST_REQ;
          set_q    <= start_set_i;
          tag_q    <= start_tag_i;
          way_q    <= start_way_i;
          beat_q   <= '0;
          poison_q <= 1'b0;
        end
        ST_REQ: begin
          if (iv_match) poison_q <= 1'b1;
          if (nl_gnt_i) st_q <= ST_FILL;
        end
        ST_FILL: begin
          if (iv_match) poison_q <= 1'b1;
          if (nl_rvalid_i) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o     = st_q;
  assign req_o       = (st_q == ST_REQ);
  assign req_addr_o  = {tag_q, set_q, {LINE_OFF{1'b0}}};
  assign fill_we_o   = (st_q == ST_FILL) && nl_rvalid_i;
  assign fill_set_o  = set_q;
  assign fill_way_o  = way_q;
  assign fill_word_o = beat_q;
  assign fill_tag_o  = tag_q;
  // line becomes valid only if no matching invalidation hit it during the fetch
  assign fill_done_o = fill_we_o && (beat_q == LAST_BEAT) && !poison_q && !iv_match;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REQ && !nl_gnt_i) |=> (req_o && $stable(req_addr_o))); // R6
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt
  import dcache_wt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CACHE_BYTES = 8192,
  parameter int unsigned LINE_BYTES  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_req_i,
  input  logic                cpu_we_i,
  input  logic [ADDR_W-1:0]   cpu_addr_i,
  input  logic [DATA_W/8-1:0] cpu_be_i,
  input  logic [DATA_W-1:0]   cpu_wdata_i,
  output logic                cpu_gnt_o,
  output logic [DATA_W-1:0]   cpu_rdata_o,
  output logic                nl_req_o,
  output logic                nl_we_o,
  output logic [ADDR_W-1:0]   nl_addr_o,
  output logic [DATA_W/8-1:0] nl_be_o,
  output logic [DATA_W-1:0]   nl_wdata_o,
  input  logic                nl_gnt_i,
  input  logic                nl_rvalid_i,
  input  logic [DATA_W-1:0]   nl_rdata_i,
  input  logic                inv_i,
  input  logic [ADDR_W-1:0]   inv_addr_i
);
  localparam int unsigned BE_W     = DATA_W / 8;
  localparam int unsigned WORD_OFF = $clog2(BE_W);
  localparam int unsigned WORDS    = LINE_BYTES / BE_W;
  localparam int unsigned WORD_W   = $clog2(WORDS);
  localparam int unsigned LINE_OFF = $clog2(LINE_BYTES);
  localparam int unsigned SETS     = CACHE_BYTES / (LINE_BYTES * NUM_WAYS);
  localparam int unsigned SET_W    = $clog2(SETS);
  localparam int unsigned TAG_W    = ADDR_W - SET_W - LINE_OFF;

  logic [SET_W-1:0]       cpu_set, inv_set, fill_set;
  logic [TAG_W-1:0]       cpu_tag, inv_tag, fill_tag;
  logic [WORD_W-1:0]      cpu_word, fill_word;
  logic [1:0]             hit_way;
  logic                   hit, victim, clash, act;
  logic                   ld_hit, ld_miss, st_go, st_commit;
  logic                   fill_we, fill_way, fill_done, miss_req;
  logic [ADDR_W-1:0]      miss_addr;
  logic [1:0][DATA_W-1:0] rd_data;
  miss_st_e               miss_st;
  logic                   inv_lo_unused;

  assign cpu_set  = cpu_addr_i[LINE_OFF +: SET_W];
  assign cpu_tag  = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign cpu_word = cpu_addr_i[WORD_OFF +: WORD_W];
  assign inv_set  = inv_addr_i[LINE_OFF +: SET_W];
  assign inv_tag  = inv_addr_i[ADDR_W-1 -: TAG_W];
  assign inv_lo_unused = ^inv_addr_i[LINE_OFF-1:0];

  // invalidation owns the set this cycle
  assign clash     = inv_i && (inv_set == cpu_set);
  assign act       = cpu_req_i && (miss_st == ST_IDLE) && !clash;
  assign hit       = |hit_way;
  assign ld_hit    = act && !cpu_we_i && hit;
  assign ld_miss   = act && !cpu_we_i && !hit;
  assign st_go     = act && cpu_we_i;
  assign st_commit = st_go && nl_gnt_i && hit;

  assign cpu_gnt_o   = ld_hit || (st_go && nl_gnt_i);
  assign cpu_rdata_o = rd_data[hit_way[1]];

  assign nl_req_o   = st_go || miss_req;
  assign nl_we_o    = st_go;
  assign nl_addr_o  = miss_req ? miss_addr : cpu_addr_i;
  assign nl_be_o    = st_go ? cpu_be_i : '1;
  assign nl_wdata_o = cpu_wdata_i;

  dc_tag_store #(
    .SET_W (SET_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_set_i    (cpu_set),
    .lk_tag_i    (cpu_tag),
    .lk_hit_o    (hit_way),
    .lk_victim_o (victim),
    .iv_en_i     (inv_i),
    .iv_set_i    (inv_set),
    .iv_tag_i    (inv_tag),
    .touch_en_i  (ld_hit || st_commit),
    .touch_set_i (cpu_set),
    .touch_way_i (hit_way[1]),
    .drop_en_i   (ld_miss),
    .drop_set_i  (cpu_set),
    .drop_way_i  (victim),
    .fill_en_i   (fill_done),
    .fill_set_i  (fill_set),
    .fill_way_i  (fill_way),
    .fill_tag_i  (fill_tag)
  );

  dc_data_store #(
    .SET_W  (SET_W),
    .WORD_W (WORD_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk_i     (clk_i),
    .rd_set_i  (cpu_set),
    .rd_word_i (cpu_word),
    .rd_data_o (rd_data),
    .wr_en_i   (fill_we || st_commit),
    .wr_way_i  (fill_we ? fill_way : hit_way[1]),
    .wr_set_i  (fill_we ? fill_set : cpu_set),
    .wr_word_i (fill_we ? fill_word : cpu_word),
    .wr_be_i   (fill_we ? {BE_W{1'b1}} : cpu_be_i),
    .wr_data_i (fill_we ? nl_rdata_i : cpu_wdata_i)
  );

  dc_miss_fsm #(
    .ADDR_W   (ADDR_W),
    .SET_W    (SET_W),
    .TAG_W    (TAG_W),
    .WORD_W   (WORD_W),
    .LINE_OFF (LINE_OFF)
  ) u_miss (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (ld_miss),
    .start_set_i (cpu_set),
    .start_tag_i (cpu_tag),
    .start_way_i (victim),
    .nl_gnt_i    (nl_gnt_i),
    .nl_rvalid_i (nl_rvalid_i),
    .iv_en_i     (inv_i),
    .iv_set_i    (inv_set),
    .iv_tag_i    (inv_tag),
    .state_o     (miss_st),
    .req_o       (miss_req),
    .req_addr_o  (miss_addr),
    .fill_we_o   (fill_we),
    .fill_set_o  (fill_set),
    .fill_way_o  (fill_way),
    .fill_word_o (fill_word),
    .fill_tag_o  (fill_tag),
    .fill_done_o (fill_done)
  );

  AST_STORE_WT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_gnt_o && cpu_we_i) |-> (nl_req_o && nl_we_o && nl_gnt_i && nl_addr_o == cpu_addr_i)); // R2
  AST_INV_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && cpu_req_i && inv_addr_i[LINE_OFF +: SET_W] == cpu_addr_i[LINE_OFF +: SET_W])
      |-> (!cpu_gnt_o && !(nl_req_o && nl_we_o))); // R9
  AST_MISS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_st != ST_IDLE) |-> !cpu_gnt_o); // R6
  AST_MISS_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miss_req) |-> !nl_we_o); // R6
endmodule

// File: tb/dcache_wt_tb_top.sv
module dcache_wt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [31:0] cpu_addr_i = '0, cpu_wdata_i = '0;
  logic [3:0]  cpu_be_i = '0;
  logic        cpu_gnt_o;
  logic [31:0] cpu_rdata_o;
  logic        nl_req_o, nl_we_o;
  logic [31:0] nl_addr_o, nl_wdata_o;
  logic [3:0]  nl_be_o;
  logic        nl_gnt_i = 1'b0, nl_rvalid_i = 1'b0;
  logic [31:0] nl_rdata_i = '0;
  logic        inv_i = 1'b0;
  logic [31:0] inv_addr_i = '0;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dcache_wt dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_be_i(cpu_be_i), .cpu_wdata_i(cpu_wdata_i),
    .cpu_gnt_o(cpu_gnt_o), .cpu_rdata_o(cpu_rdata_o),
    .nl_req_o(nl_req_o), .nl_we_o(nl_we_o), .nl_addr_o(nl_addr_o),
    .nl_be_o(nl_be_o), .nl_wdata_o(nl_wdata_o),
    .nl_gnt_i(nl_gnt_i), .nl_rvalid_i(nl_rvalid_i), .nl_rdata_i(nl_rdata_i),
    .inv_i(inv_i), .inv_addr_i(inv_addr_i)
  );

  // ---------------- next-level memory model ----------------
  logic [31:0] bmem [logic [31:0]];
  int          rd_reqs = 0, wr_cnt = 0, beat = 0, gcnt = 0;
  bit          req_wait = 0, fill_pend = 0;
  logic [31:0] last_wa = '0, last_wd = '0, last_ra = '0, fill_line = '0;
  logic [3:0]  last_wbe = '0;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    if (bmem.exists(w)) return bmem[w];
    return {w[15:0] ^ 16'hc3a5, w[15:0]};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  always @(negedge clk) begin
    nl_gnt_i = req_wait;
    if (fill_pend && (gcnt % 3 != 2)) begin
      nl_rvalid_i = 1'b1;
      nl_rdata_i  = mem_rd(fill_line + 32'(beat * 4));
    end else begin
      nl_rvalid_i = 1'b0;
      nl_rdata_i  = '0;
    end
    if (fill_pend) gcnt++;
    #2;
    if (nl_rvalid_i) begin
      beat++;
      if (beat == 8) fill_pend = 0;
    end
    if (nl_req_o && nl_gnt_i) begin
      req_wait = 0;
      if (nl_we_o) begin
        wr_cnt++;
        last_wa = nl_addr_o; last_wd = nl_wdata_o; last_wbe = nl_be_o;
        bmem[{nl_addr_o[31:2], 2'b00}] = merge(mem_rd(nl_addr_o), nl_wdata_o, nl_be_o);
      end else begin
        rd_reqs++;
        last_ra = nl_addr_o;
        fill_pend = 1; beat = 0; gcnt = 0; fill_line = nl_addr_o;
      end
    end else begin
      req_wait = nl_req_o;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_be_i = be; cpu_wdata_i = wd;
    cyc = 0; rd = '0;
    forever begin
      #3;
      cyc++;
      if (cpu_gnt_o) begin
        rd = cpu_rdata_o;
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    cpu_req_i = 1'b0; cpu_we_i = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        miss;
  } vec_t;

  localparam int NV = 15;
  // set index 2: A tag 1, B tag 2, C tag 3; D in set 8
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_1040, 4'h0, 32'h0, 1'b1},         // A first touch misses (R11, R6)
    '{1'b0, 32'h0000_1044, 4'h0, 32'h0, 1'b0},         // same line hit (R5)
    '{1'b0, 32'h0000_2040, 4'h0, 32'h0, 1'b1},         // B fills other way (R1)
    '{1'b0, 32'h0000_1040, 4'h0, 32'h0, 1'b0},         // A still resident (R1, R7)
    '{1'b0, 32'h0000_3040, 4'h0, 32'h0, 1'b1},         // C evicts B (R7)
    '{1'b0, 32'h0000_1040, 4'h0, 32'h0, 1'b0},         // A survives (R7)
    '{1'b0, 32'h0000_2040, 4'h0, 32'h0, 1'b1},         // B refetched, evicts C (R7)
    '{1'b1, 32'h0000_1040, 4'h3, 32'hDEAD_BEEF, 1'b0}, // store hit (R2, R4)
    '{1'b0, 32'h0000_1040, 4'h0, 32'h0, 1'b0},         // merged word (R4)
    '{1'b1, 32'h0000_0100, 4'hF, 32'h1234_5678, 1'b1}, // store miss (R3)
    '{1'b0, 32'h0000_0100, 4'h0, 32'h0, 1'b1},         // not allocated (R3)
    '{1'b1, 32'h0000_0108, 4'h8, 32'hAB00_0000, 1'b0}, // store hit one byte (R4)
    '{1'b0, 32'h0000_0108, 4'h0, 32'h0, 1'b0},         // merged byte (R4)
    '{1'b0, 32'h0000_3040, 4'h0, 32'h0, 1'b1},         // C evicts B again (R7)
    '{1'b0, 32'h0000_1040, 4'h0, 32'h0, 1'b0}          // A hit (R7)
  };

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL R11 watchdog: actual %h expected %h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    vec_t        v;
    int          r0, w0, cyc;
    logic [31:0] rd;

    repeat (3) @(negedge clk);
    #3;
    chk(cpu_gnt_o == 1'b0, "R11 gnt low in reset", {31'd0, cpu_gnt_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(cpu_gnt_o == 1'b0, "R11 gnt low idle", {31'd0, cpu_gnt_o}, 32'd0);
    chk(nl_req_o == 1'b0, "R11 nl_req low idle", {31'd0, nl_req_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      r0 = rd_reqs;
      w0 = wr_cnt;
      access(v.we, v.addr, v.be, v.wd, rd, cyc);
      if (v.we) begin
        chk(wr_cnt == w0 + 1, "R2 store forwarded", 32'(wr_cnt - w0), 32'd1);
        chk(last_wa == v.addr && last_wbe == v.be, "R2 write addr/be", last_wa, v.addr);
        chk(last_wd == v.wd, "R2 write data", last_wd, v.wd);
        chk(cyc == 2, "R2 grant follows nl_gnt", 32'(cyc), 32'd2);
        chk(rd_reqs == r0, "R3 store causes no fetch", 32'(rd_reqs - r0), 32'd0);
      end else begin
        chk(rd == mem_rd(v.addr), "R4 R6 load data", rd, mem_rd(v.addr));
        chk(rd_reqs - r0 == (v.miss ? 1 : 0), "R7 R1 hit/miss pattern",
            32'(rd_reqs - r0), {31'd0, v.miss});
        if (v.miss)
          chk(last_ra == {v.addr[31:5], 5'b0}, "R6 line aligned read", last_ra, {v.addr[31:5], 5'b0});
        else
          chk(cyc == 1, "R5 one-cycle hit", 32'(cyc), 32'd1);
      end
    end

    // R8: matching invalidation drops A
    @(negedge clk);
    inv_i = 1'b1; inv_addr_i = 32'h0000_1040;
    @(negedge clk);
    inv_i = 1'b0;
    r0 = rd_reqs;
    access(1'b0, 32'h0000_1040, 4'h0, 32'h0, rd, cyc);
    chk(rd_reqs == r0 + 1, "R8 invalidated line misses", 32'(rd_reqs - r0), 32'd1);
    chk(rd == mem_rd(32'h0000_1040), "R8 refetched data", rd, mem_rd(32'h0000_1040));

    // R8: non-matching tag in same set has no effect
    @(negedge clk);
    inv_i = 1'b1; inv_addr_i = 32'h0000_5040;
    @(negedge clk);
    inv_i = 1'b0;
    r0 = rd_reqs;
    access(1'b0, 32'h0000_1040, 4'h0, 32'h0, rd, cyc);
    chk(rd_reqs == r0 && cyc == 1, "R8 unmatched invalidate ignored", 32'(rd_reqs - r0), 32'd0);

    // R9: same-set invalidation stalls a store for that cycle
    w0 = wr_cnt;
    @(negedge clk);
    cpu_req_i = 1'b1; cpu_we_i = 1'b1; cpu_addr_i = 32'h0000_1040;
    cpu_be_i = 4'hF; cpu_wdata_i = 32'h5555_AAAA;
    inv_i = 1'b1; inv_addr_i = 32'h0000_5040;
    #3;
    chk(cpu_gnt_o == 1'b0, "R9 no grant under invalidate", {31'd0, cpu_gnt_o}, 32'd0);
    chk(nl_req_o == 1'b0, "R9 no write under invalidate", {31'd0, nl_req_o}, 32'd0);
    @(negedge clk);
    inv_i = 1'b0;
    forever begin
      #3;
      if (cpu_gnt_o) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    cpu_req_i = 1'b0; cpu_we_i = 1'b0;
    chk(wr_cnt == w0 + 1, "R9 store proceeds later", 32'(wr_cnt - w0), 32'd1);
    r0 = rd_reqs;
    access(1'b0, 32'h0000_1040, 4'h0, 32'h0, rd, cyc);
    chk(rd == 32'h5555_AAAA && rd_reqs == r0, "R9 R4 stored word hits", rd, 32'h5555_AAAA);

    // R10: invalidation during the fill cancels it
    r0 = rd_reqs;
    fork
      access(1'b0, 32'h0000_7304, 4'h0, 32'h0, rd, cyc);
      begin
        wait (rd_reqs == r0 + 1);
        @(negedge clk);
        inv_i = 1'b1; inv_addr_i = 32'h0000_7300;
        @(negedge clk);
        inv_i = 1'b0;
      end
    join
    chk(rd_reqs == r0 + 2, "R10 poisoned fill refetched", 32'(rd_reqs - r0), 32'd2);
    chk(rd == mem_rd(32'h0000_7304), "R10 data after refetch", rd, mem_rd(32'h0000_7304));
    r0 = rd_reqs;
    access(1'b0, 32'h0000_7304, 4'h0, 32'h0, rd, cyc);
    chk(rd_reqs == r0 && cyc == 1, "R10 clean refill hits", 32'(rd_reqs - r0), 32'd0);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule